// File: doc/BRIEF.md
# Passive Parallel Configuration Sequencer

This block steps an FPGA that loads its image over a passive parallel port from power-on up to user mode. It owns the control lines toward the device: the configuration-reset line, the active-low chip enable, two active-low override enables (one for the configuration logic and one for the reset line), and the enables of the data path and of the control path. It watches the device's reset line, its status line, its done line, the done line's output enable, the user-mode flag and the mode-select pins. Moving the image data itself is outside the block. The block only opens and closes the data path around it.

Two one-cycle commands drive it. The init command checks the mode pins and waits for the device to be quiet. It then takes control of the pins, pulses the reset line, and checks the done line. When all of that succeeds it opens the paths and raises `init_done_o`. The host then streams the image and issues the finish command. The block polls the done line, asks once for a burst of extra configuration clocks, and waits for user mode. It then hands the pins back and makes a final pin check. Every wait is bounded by a cycle-count limit. Any failure stops the sequence and reports a coded error.

Top module: `ppcfg_sequencer`

## Requirements
- R1: After reset, and again whenever an init command is accepted, the outputs take idle values. These are `nconfig_o`=1, `nce_o`=1, both override enables at 1, both path enables at 0, `dclk_req_o`=0 and `busy_o`=0. After reset, and on acceptance of init, the flags `init_done_o`, `cfg_done_o` and `err_o` are 0 and `err_code_o` is 0.
- R2: If init is issued while any mode-select bit other than bit 0 is 1, the block stops with `err_code_o`=1 and drives nothing: `nce_o` and both override enables stay 1. The mode values 0 and 1 are accepted.
- R3: Before driving any pin, the block waits for the device reset line and the status line to both read 1. If that takes `TIMEOUT_CYC` cycles, it stops with `err_code_o`=2 (timeout), and `nce_o` is still 1.
- R4: After that check, the block releases all drives and then asserts both overrides (0) and drives `nce_o` low, keeping `nconfig_o` high and both paths off. It then waits again for the reset line and the status line to both read 1.
- R5: The reset pulse holds `nconfig_o` low until the status line reads 0. It then holds `nconfig_o` high until the status line reads 1. Each of these waits ends in error 2 after `TIMEOUT_CYC` cycles, leaving `nconfig_o` where it was.
- R6: After the pulse, the done line must read 0 and its output enable must read 1. Otherwise the block stops with `err_code_o`=3 (pin check). On success, both path enables go to 1 and `init_done_o` goes to 1.
- R7: The finish command is taken only after a successful init. The block then polls the done line for at most `POLL_LIMIT` cycles. If the limit is reached, it stops with error 2. If the status line reads 0 while the done line still reads 0, it stops with `err_code_o`=4. When the done line reads 1 in the same cycle as the status line reads 0, the done line wins.
- R8: When the done line is seen, `dclk_req_o` is 1 for exactly one cycle, and `dclk_len_o` carries `DCLK_EXTRA` (15 by default).
- R9: After the clock request, the block waits for the user-mode flag. If `TIMEOUT_CYC` cycles pass without it, the block stops with error 2.
- R10: When user mode is seen, the block closes both paths, drives both overrides and `nce_o` back to 1, and then requires user mode, the done line and the status line to all read 1. If they do, `cfg_done_o` goes to 1. If not, the block stops with error 3.
- R11: Every monitored input passes through two flip-flops. A change applied between clock edges reaches the outputs on the third rising edge after it, and not before.
- R12: Init is ignored while a sequence is running (`busy_o`=1). Finish is ignored in any state other than the one reached by a successful init.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_init | input | 1 | One-cycle command: run the init sequence |
| start_finish | input | 1 | One-cycle command: run the finish sequence |
| msel_i | input | MSEL_W | Mode-select pins |
| nconfig_pin_i | input | 1 | Device reset line as read back |
| nstatus_pin_i | input | 1 | Device status line |
| confdone_pin_i | input | 1 | Device done line |
| confdone_oe_i | input | 1 | Output enable of the done line |
| usermode_i | input | 1 | Device reports user mode |
| nconfig_o | output | 1 | Drive of the device reset line, active low |
| nce_o | output | 1 | Chip enable, active low |
| ovr_cfg_n_o | output | 1 | Configuration override enable, active low |
| ovr_ncfg_n_o | output | 1 | Reset-line override enable, active low |
| data_en_o | output | 1 | Data path enable |
| ctrl_en_o | output | 1 | Control path enable |
| dclk_req_o | output | 1 | One-cycle request for an extra clock burst |
| dclk_len_o | output | DLEN_W | Length of the requested burst |
| busy_o | output | 1 | A sequence is running |
| init_done_o | output | 1 | Init completed |
| cfg_done_o | output | 1 | Device reached user mode and passed the final check |
| err_o | output | 1 | The sequence stopped on an error |
| err_code_o | output | 3 | 0 none, 1 mode, 2 timeout, 3 pin check, 4 status lost |

## Verification
Two pairs of events can reach the state machine in the same cycle. In the first pair, the done line rises while the status line drops during the finish poll. The bench changes both pins on the same falling edge, so they leave the synchronizers together. The result is judged correct if exactly one clock request appears and no code 4 is reported, followed by error 3 once user mode arrives with the status line still low. In the second pair, user mode and a low status line arrive together. That case must end in the pin-check error, not in success.

// File: rtl/ppcfg_pkg.sv
package ppcfg_pkg;

  typedef enum logic [2:0] {
    ERR_NONE    = 3'd0,
    ERR_MODE    = 3'd1,
    ERR_TIMEOUT = 3'd2,
    ERR_PIN     = 3'd3,
    ERR_NSTAT   = 3'd4
  } err_code_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PRE_WAIT,
    ST_RELEASE,
    ST_OVR,
    ST_MID_WAIT,
    ST_PULSE_LO,
    ST_PULSE_HI,
    ST_PIN_CHK,
    ST_READY,
    ST_POLL_CD,
    ST_WAIT_UM,
    ST_FINAL,
    ST_DONE,
    ST_FAIL
  } seq_state_e;

  // Registered drive toward the device
  typedef struct packed {
    logic nconfig;
    logic nce;
    logic ovr_cfg_n;
    logic ovr_ncfg_n;
    logic data_en;
    logic ctrl_en;
  } drive_t;

  localparam drive_t DRV_IDLE = '{nconfig: 1'b1, nce: 1'b1, ovr_cfg_n: 1'b1,
                                  ovr_ncfg_n: 1'b1, data_en: 1'b0, ctrl_en: 1'b0};

endpackage

// File: rtl/ppcfg_sync2.sv
module ppcfg_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[b] <= 1'b0;
        sync_q[b] <= 1'b0;
      end else begin
        meta_q[b] <= d[b];
        sync_q[b] <= meta_q[b];
      end
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/ppcfg_wait_timer.sv
module ppcfg_wait_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic [CW-1:0] limit,
  output logic          expired
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (en)  cnt_q <= cnt_q + 1'b1;
  end

  assign expired = en && (cnt_q == limit - 1'b1);
endmodule

// File: rtl/ppcfg_sequencer.sv
module ppcfg_sequencer
  import ppcfg_pkg::*;
#(
  parameter int MSEL_W      = 3,
  parameter int TIMEOUT_CYC = 250000,
  parameter int POLL_LIMIT  = 16777216,
  parameter int DCLK_EXTRA  = 15,
  parameter int DLEN_W      = $clog2(DCLK_EXTRA + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_init,
  input  logic              start_finish,
  input  logic [MSEL_W-1:0] msel_i,
  input  logic              nconfig_pin_i,
  input  logic              nstatus_pin_i,
  input  logic              confdone_pin_i,
  input  logic              confdone_oe_i,
  input  logic              usermode_i,
  output logic              nconfig_o,
  output logic              nce_o,
  output logic              ovr_cfg_n_o,
  output logic              ovr_ncfg_n_o,
  output logic              data_en_o,
  output logic              ctrl_en_o,
  output logic              dclk_req_o,
  output logic [DLEN_W-1:0] dclk_len_o,
  output logic              busy_o,
  output logic              init_done_o,
  output logic              cfg_done_o,
  output logic              err_o,
  output logic [2:0]        err_code_o
);

  localparam int LIM_MAX = (TIMEOUT_CYC > POLL_LIMIT) ? TIMEOUT_CYC : POLL_LIMIT;
  localparam int CW      = $clog2(LIM_MAX + 1);
  localparam int SW      = MSEL_W + 5;
  localparam logic [MSEL_W-1:0] MSEL_OK = MSEL_W'(1);

  // Synchronized pin view
  logic [SW-1:0]     pins_s;
  logic [MSEL_W-1:0] msel_s;
  logic nconfig_s, nstatus_s, confdone_s, cdoe_s, usermode_s;

  ppcfg_sync2 #(.W(SW)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({usermode_i, confdone_oe_i, confdone_pin_i, nstatus_pin_i, nconfig_pin_i, msel_i}),
    .q    (pins_s)
  );

  assign {usermode_s, cdoe_s, confdone_s, nstatus_s, nconfig_s, msel_s} = pins_s;

  // State and registered outputs
  seq_state_e state_q, state_d;
  drive_t     drv_q, drv_d;
  err_code_e  code_q, code_d;
  logic       err_q, err_d;
  logic       ini_q, ini_d;
  logic       cfg_q, cfg_d;
  logic       dclk_q, dclk_d;

  logic          tmr_en;
  logic          tmr_exp;
  logic [CW-1:0] tmr_lim;
  logic          idle_like;
  logic          start_go;

  assign idle_like = (state_q == ST_IDLE) || (state_q == ST_READY) ||
                     (state_q == ST_DONE) || (state_q == ST_FAIL);
  assign start_go  = start_init && idle_like;

  ppcfg_wait_timer #(.CW(CW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (state_d != state_q),
    .en     (tmr_en),
    .limit  (tmr_lim),
    .expired(tmr_exp)
  );

  // Next-state process
  always_comb begin
    state_d = state_q;
    drv_d   = drv_q;
    code_d  = code_q;
    err_d   = err_q;
    ini_d   = ini_q;
    cfg_d   = cfg_q;
    dclk_d  = 1'b0;
    tmr_en  = 1'b0;
    tmr_lim = CW'(TIMEOUT_CYC);

    if (start_go) begin
      drv_d  = DRV_IDLE;
      err_d  = 1'b0;
      code_d = ERR_NONE;
      ini_d  = 1'b0;
      cfg_d  = 1'b0;
      if ((msel_s & ~MSEL_OK) != '0) begin
        state_d = ST_FAIL;
        err_d   = 1'b1;
        code_d  = ERR_MODE;
      end else begin
        state_d = ST_PRE_WAIT;
      end
    end else begin
      unique case (state_q)
        ST_READY: begin
          if (start_finish) begin
            ini_d   = 1'b0;
            state_d = ST_POLL_CD;
          end
        end
        ST_PRE_WAIT, ST_MID_WAIT: begin
          tmr_en = 1'b1;
          if (nconfig_s && nstatus_s) begin
            if (state_q == ST_PRE_WAIT) begin
              state_d = ST_RELEASE;
            end else begin
              drv_d.nconfig = 1'b0;
              state_d       = ST_PULSE_LO;
            end
          end else if (tmr_exp) begin
            state_d = ST_FAIL;
            err_d   = 1'b1;
            code_d  = ERR_TIMEOUT;
          end
        end
        ST_RELEASE: begin
          drv_d.nce     = 1'b1;
          drv_d.nconfig = 1'b1;
          drv_d.data_en = 1'b0;
          drv_d.ctrl_en = 1'b0;
          state_d       = ST_OVR;
        end
        ST_OVR: begin
          drv_d.ovr_cfg_n  = 1'b0;
          drv_d.ovr_ncfg_n = 1'b0;
          drv_d.nce        = 1'b0;
          state_d          = ST_MID_WAIT;
        end
        ST_PULSE_LO: begin
          tmr_en = 1'b1;
          if (!nstatus_s) begin
            drv_d.nconfig = 1'b1;
            state_d       = ST_PULSE_HI;
          end else if (tmr_exp) begin
            state_d = ST_FAIL;
            err_d   = 1'b1;
            code_d  = ERR_TIMEOUT;
          end
        end
        ST_PULSE_HI: begin
          tmr_en = 1'b1;
          if (nstatus_s) begin
            state_d = ST_PIN_CHK;
          end else if (tmr_exp) begin
            state_d = ST_FAIL;
            err_d   = 1'b1;
            code_d  = ERR_TIMEOUT;
          end
        end
        ST_PIN_CHK: begin
          if (!confdone_s && cdoe_s) begin
            drv_d.data_en = 1'b1;
            drv_d.ctrl_en = 1'b1;
            ini_d         = 1'b1;
            state_d       = ST_READY;
          end else begin
            state_d = ST_FAIL;
            err_d   = 1'b1;
            code_d  = ERR_PIN;
          end
        end
        ST_POLL_CD: begin
          tmr_en  = 1'b1;
          tmr_lim = CW'(POLL_LIMIT);
          if (confdone_s) begin
            dclk_d  = 1'b1;
            state_d = ST_WAIT_UM;
          end else if (!nstatus_s) begin
            state_d = ST_FAIL;
            err_d   = 1'b1;
            code_d  = ERR_NSTAT;
          end else if (tmr_exp) begin
            state_d = ST_FAIL;
            err_d   = 1'b1;
            code_d  = ERR_TIMEOUT;
          end
        end
        ST_WAIT_UM: begin
          tmr_en = 1'b1;
          if (usermode_s) begin
            drv_d.data_en    = 1'b0;
            drv_d.ctrl_en    = 1'b0;
            drv_d.ovr_cfg_n  = 1'b1;
            drv_d.ovr_ncfg_n = 1'b1;
            drv_d.nce        = 1'b1;
            state_d          = ST_FINAL;
          end else if (tmr_exp) begin
            state_d = ST_FAIL;
            err_d   = 1'b1;
            code_d  = ERR_TIMEOUT;
          end
        end
        ST_FINAL: begin
          if (usermode_s && confdone_s && nstatus_s) begin
            cfg_d   = 1'b1;
            state_d = ST_DONE;
          end else begin
            state_d = ST_FAIL;
            err_d   = 1'b1;
            code_d  = ERR_PIN;
          end
        end
        default: ;
      endcase
    end
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      drv_q   <= DRV_IDLE;
      code_q  <= ERR_NONE;
      err_q   <= 1'b0;
      ini_q   <= 1'b0;
      cfg_q   <= 1'b0;
      dclk_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      drv_q   <= drv_d;
      code_q  <= code_d;
      err_q   <= err_d;
      ini_q   <= ini_d;
      cfg_q   <= cfg_d;
      dclk_q  <= dclk_d;
    end
  end

  assign nconfig_o    = drv_q.nconfig;
  assign nce_o        = drv_q.nce;
  assign ovr_cfg_n_o  = drv_q.ovr_cfg_n;
  assign ovr_ncfg_n_o = drv_q.ovr_ncfg_n;
  assign data_en_o    = drv_q.data_en;
  assign ctrl_en_o    = drv_q.ctrl_en;
  assign dclk_req_o   = dclk_q;
  assign dclk_len_o   = DLEN_W'(DCLK_EXTRA);
  assign busy_o       = !idle_like;
  assign init_done_o  = ini_q;
  assign cfg_done_o   = cfg_q;
  assign err_o        = err_q;
  assign err_code_o   = code_q;

endmodule

// File: rtl/ppcfg_sequencer_chk.sv
module ppcfg_sequencer_chk
  import ppcfg_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       nconfig_o,
  input logic       nce_o,
  input logic       ovr_cfg_n_o,
  input logic       ovr_ncfg_n_o,
  input logic       data_en_o,
  input logic       ctrl_en_o,
  input logic       dclk_req_o,
  input logic       init_done_o,
  input logic       cfg_done_o,
  input logic       err_o,
  input logic [2:0] err_code_o
);

  assert_mode_err_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && err_code_o == ERR_MODE) |-> (nce_o && ovr_cfg_n_o && ovr_ncfg_n_o));

  assert_ovr_before_nce_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !nce_o |-> (!ovr_cfg_n_o && !ovr_ncfg_n_o));

  assert_pulse_selected_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !nconfig_o |-> (!nce_o && !data_en_o));

  assert_path_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_en_o) |-> (nconfig_o && !nce_o && !ovr_cfg_n_o && init_done_o));

  assert_paths_paired_R6: assert property (@(posedge clk) disable iff (!rst_n)
    data_en_o == ctrl_en_o);

  assert_dclk_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dclk_req_o |=> !dclk_req_o);

  assert_teardown_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_done_o) |-> (nce_o && !data_en_o && ovr_cfg_n_o && ovr_ncfg_n_o));

  assert_flags_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_o && (cfg_done_o || init_done_o)));

endmodule

bind ppcfg_sequencer ppcfg_sequencer_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .nconfig_o   (nconfig_o),
  .nce_o       (nce_o),
  .ovr_cfg_n_o (ovr_cfg_n_o),
  .ovr_ncfg_n_o(ovr_ncfg_n_o),
  .data_en_o   (data_en_o),
  .ctrl_en_o   (ctrl_en_o),
  .dclk_req_o  (dclk_req_o),
  .init_done_o (init_done_o),
  .cfg_done_o  (cfg_done_o),
  .err_o       (err_o),
  .err_code_o  (err_code_o)
);

// File: tb/tb_ppcfg_sequencer.sv
`timescale 1ns/1ps
module tb_ppcfg_sequencer;

  localparam int MSEL_W = 3;
  localparam int TMO    = 64;
  localparam int POLL   = 100;
  localparam int DEXTRA = 15;
  localparam int DLW    = $clog2(DEXTRA + 1);

  localparam int K_INIT = 0;
  localparam int K_CFG  = 1;
  localparam int K_ERR  = 2;

  logic clk, rst_n;
  logic start_init, start_finish;
  logic [MSEL_W-1:0] msel_i;
  logic nconfig_pin_i, nstatus_pin_i, confdone_pin_i, confdone_oe_i, usermode_i;
  logic nconfig_o, nce_o, ovr_cfg_n_o, ovr_ncfg_n_o, data_en_o, ctrl_en_o;
  logic dclk_req_o, busy_o, init_done_o, cfg_done_o, err_o;
  logic [DLW-1:0] dclk_len_o;
  logic [2:0] err_code_o;

  ppcfg_sequencer #(
    .MSEL_W(MSEL_W), .TIMEOUT_CYC(TMO), .POLL_LIMIT(POLL), .DCLK_EXTRA(DEXTRA)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start_init(start_init), .start_finish(start_finish),
    .msel_i(msel_i), .nconfig_pin_i(nconfig_pin_i), .nstatus_pin_i(nstatus_pin_i),
    .confdone_pin_i(confdone_pin_i), .confdone_oe_i(confdone_oe_i), .usermode_i(usermode_i),
    .nconfig_o(nconfig_o), .nce_o(nce_o), .ovr_cfg_n_o(ovr_cfg_n_o), .ovr_ncfg_n_o(ovr_ncfg_n_o),
    .data_en_o(data_en_o), .ctrl_en_o(ctrl_en_o), .dclk_req_o(dclk_req_o), .dclk_len_o(dclk_len_o),
    .busy_o(busy_o), .init_done_o(init_done_o), .cfg_done_o(cfg_done_o), .err_o(err_o),
    .err_code_o(err_code_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 0;
  bit auto_dev = 0;
  int dclk_seen = 0;

  typedef struct {
    int    kind;
    int    code;
    string req;
  } exp_t;
  exp_t exp_q[$];

  task automatic chk(string req, int act, int exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push_exp(int kind, int code, string req);
    exp_t e;
    e.kind = kind; e.code = code; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic got_event(int kind, int code);
    exp_t e;
    n_chk++;
    if (exp_q.size() == 0) begin
      n_fail++;
      $display("FAIL R12 unexpected event: actual kind %0d code %0d expected none", kind, code);
    end else begin
      e = exp_q.pop_front();
      if (e.kind != kind || e.code != code) begin
        n_fail++;
        $display("FAIL %s event: actual kind %0d code %0d expected kind %0d code %0d",
                 e.req, kind, code, e.kind, e.code);
      end
    end
  endtask

  task automatic wait_events(string req);
    for (int i = 0; i < 2000 && exp_q.size() != 0; i++) @(negedge clk);
    n_chk++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL %s missing event: actual pending %0d expected 0", req, exp_q.size());
      exp_q.delete();
    end
  endtask

  task automatic pulse_init();
    @(negedge clk) start_init = 1'b1;
    @(negedge clk) start_init = 1'b0;
  endtask

  task automatic pulse_finish();
    @(negedge clk) start_finish = 1'b1;
    @(negedge clk) start_finish = 1'b0;
  endtask

  task automatic pins_normal();
    nconfig_pin_i  = 1'b1;
    nstatus_pin_i  = 1'b1;
    confdone_pin_i = 1'b0;
    confdone_oe_i  = 1'b1;
    usermode_i     = 1'b0;
    msel_i         = '0;
  endtask

  task automatic init_ok();
    pins_normal();
    auto_dev = 1;
    repeat (4) @(negedge clk);
    push_exp(K_INIT, 0, "R6");
    pulse_init();
    wait_events("R6");
  endtask

  // Device model: status line follows the reset drive a few cycles later
  initial begin
    logic [2:0] dly;
    dly = 3'b111;
    forever begin
      @(negedge clk);
      dly = {dly[1:0], nconfig_o};
      if (auto_dev) nstatus_pin_i = dly[2];
    end
  end

  // Monitor: compares produced outcomes with the expected queue
  initial begin
    logic p_ini, p_cfg, p_err;
    p_ini = 0; p_cfg = 0; p_err = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (init_done_o && !p_ini) got_event(K_INIT, 0);
        if (cfg_done_o && !p_cfg)  got_event(K_CFG, 0);
        if (err_o && !p_err)       got_event(K_ERR, int'(err_code_o));
        if (dclk_req_o)            dclk_seen++;
      end
      p_ini = init_done_o; p_cfg = cfg_done_o; p_err = err_o;
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0; start_init = 0; start_finish = 0;
    pins_normal();
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset values
    chk("R1", nconfig_o, 1, "nconfig_o");
    chk("R1", nce_o, 1, "nce_o");
    chk("R1", ovr_cfg_n_o & ovr_ncfg_n_o, 1, "overrides");
    chk("R1", data_en_o | ctrl_en_o | dclk_req_o | busy_o, 0, "enables/busy");
    chk("R1", init_done_o | cfg_done_o | err_o, 0, "flags");
    chk("R1", err_code_o, 0, "err_code_o");

    // R12 finish ignored when not ready
    pulse_finish();
    repeat (5) @(negedge clk);
    chk("R12", busy_o, 0, "busy after stray finish");
    chk("R12", nce_o, 1, "nce after stray finish");

    // R2 mode-select rejection
    msel_i = 3'b010;
    repeat (4) @(negedge clk);
    push_exp(K_ERR, 1, "R2");
    pulse_init();
    wait_events("R2");
    chk("R2", nce_o, 1, "nce after mode error");
    chk("R2", ovr_cfg_n_o & ovr_ncfg_n_o, 1, "overrides after mode error");

    // R3 pre-check timeout; R12 init ignored while busy; mode 1 accepted
    pins_normal();
    msel_i = 3'b001;
    nstatus_pin_i = 1'b0;
    repeat (4) @(negedge clk);
    push_exp(K_ERR, 2, "R3");
    pulse_init();
    repeat (20) @(negedge clk);
    chk("R3", nce_o, 1, "nce while waiting for pins");
    chk("R3", busy_o, 1, "busy while waiting");
    msel_i = 3'b011;
    repeat (3) @(negedge clk);
    pulse_init();
    wait_events("R3");
    chk("R1", err_o, 1, "error held");

    // R4 R5 R11 R6 manual init
    pins_normal();
    auto_dev = 0;
    repeat (4) @(negedge clk);
    push_exp(K_INIT, 0, "R6");
    pulse_init();
    chk("R1", err_o | busy_o, 1, "busy after accepted init");
    for (int i = 0; i < 50 && nce_o !== 1'b0; i++) @(negedge clk);
    chk("R4", nce_o, 0, "nce driven low");
    chk("R4", ovr_cfg_n_o | ovr_ncfg_n_o, 0, "overrides active");
    chk("R4", nconfig_o, 1, "nconfig held high");
    chk("R4", data_en_o | ctrl_en_o, 0, "paths off");
    for (int i = 0; i < 50 && nconfig_o !== 1'b0; i++) @(negedge clk);
    chk("R5", nconfig_o, 0, "pulse low");
    repeat (4) @(negedge clk);
    chk("R5", nconfig_o, 0, "pulse held until status low");
    nstatus_pin_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R11", nconfig_o, 0, "no response after two edges");
    @(negedge clk);
    chk("R11", nconfig_o, 1, "response on third edge");
    nstatus_pin_i = 1'b1;
    wait_events("R6");
    chk("R6", data_en_o & ctrl_en_o, 1, "paths open");

    // R6 pin check failure (done line output enable low)
    pins_normal();
    confdone_oe_i = 1'b0;
    auto_dev = 1;
    repeat (4) @(negedge clk);
    push_exp(K_ERR, 3, "R6");
    pulse_init();
    wait_events("R6");
    chk("R6", data_en_o, 0, "paths stay closed");

    // R5 timeout waiting for status low
    pins_normal();
    auto_dev = 0;
    repeat (4) @(negedge clk);
    push_exp(K_ERR, 2, "R5");
    pulse_init();
    wait_events("R5");
    chk("R5", nconfig_o, 0, "nconfig left low");

    // R7 R8 R10 full success
    init_ok();
    dclk_seen = 0;
    push_exp(K_CFG, 0, "R10");
    pulse_finish();
    repeat (10) @(negedge clk);
    confdone_pin_i = 1'b1;
    repeat (10) @(negedge clk);
    chk("R8", dclk_seen, 1, "one clock request");
    chk("R8", dclk_len_o, DEXTRA, "burst length");
    chk("R7", err_o, 0, "no error after done line");
    usermode_i = 1'b1;
    wait_events("R10");
    chk("R10", nce_o & ovr_cfg_n_o & ovr_ncfg_n_o, 1, "pins handed back");
    chk("R10", data_en_o | ctrl_en_o, 0, "paths closed");

    // R7 poll limit
    init_ok();
    push_exp(K_ERR, 2, "R7");
    pulse_finish();
    repeat (POLL / 2) @(negedge clk);
    chk("R7", err_o, 0, "no early poll timeout");
    wait_events("R7");

    // R7 status lost during poll
    init_ok();
    auto_dev = 0;
    push_exp(K_ERR, 4, "R7");
    pulse_finish();
    repeat (5) @(negedge clk);
    nstatus_pin_i = 1'b0;
    wait_events("R7");

    // R7 same-cycle done and status loss; R10 final check fails
    init_ok();
    auto_dev = 0;
    dclk_seen = 0;
    push_exp(K_ERR, 3, "R10");
    pulse_finish();
    repeat (5) @(negedge clk);
    confdone_pin_i = 1'b1;
    nstatus_pin_i  = 1'b0;
    repeat (10) @(negedge clk);
    chk("R7", dclk_seen, 1, "done line wins over status loss");
    chk("R7", err_o, 0, "no status-lost error");
    usermode_i = 1'b1;
    wait_events("R10");

    // R9 user mode timeout
    init_ok();
    push_exp(K_ERR, 2, "R9");
    pulse_finish();
    repeat (5) @(negedge clk);
    confdone_pin_i = 1'b1;
    wait_events("R9");

    repeat (5) @(negedge clk);
    chk("R12", exp_q.size(), 0, "no stray events");
    finish_run();
  end

endmodule